// File: doc/BRIEF.md
# Packed Decimal Add/Subtract Unit

This block adds or subtracts two signed packed-decimal numbers, one byte per cycle. Each operand is a field of 1 to 16 bytes. Every byte holds two decimal digits, except the lowest byte: its low nibble is the sign. Values are kept as a magnitude plus a separate sign, never as a complement. The two operands have independent lengths. The result takes the length of the first operand (A).

A command is accepted with `start` while `ready` is high. The command carries the operation, the sign style for the result and the two length codes. The operand bytes then arrive together on `a_byte` and `b_byte`, lowest-order byte first, one pair per cycle in which `in_valid` is high. After the last input byte, the unit makes a second internal pass over the stored partial result. In that pass it turns a borrowed difference back into a true magnitude and works out the zero and overflow status. It then streams the result bytes out, lowest-order first. It reports a condition code, an overflow flag and a data-error flag together with the last result byte.

Top module: `pdec_addsub_unit`

## Requirements
- R1: A used digit nibble of 1010..1111, or a sign nibble of 0000..1001 in either operand, sets `data_err`. `done` is then pulsed one cycle after the last input byte, no result bytes are emitted, and `cc` is 00 with `overflow` 0.
- R2: Sign nibbles 1011 and 1101 mean negative. Sign nibbles 1010, 1100, 1110 and 1111 mean positive.
- R3: The result sign is written in the low nibble of the first output byte. With `sign_mode`=0 it is 1100 for plus and 1101 for minus. With `sign_mode`=1 it is 1010 for plus and 1011 for minus.
- R4: With `op_sub`=0 the result is A+B; with `op_sub`=1 it is A-B. The result is a decimal magnitude with every digit nibble in 0000..1001.
- R5: The length codes give the byte count minus one. The input stream is max(`len_a`,`len_b`)+1 bytes long. Byte 0 carries digit 0 in bits 7:4 and the sign in bits 3:0. Byte k>0 carries digit 2k in bits 7:4 and digit 2k-1 in bits 3:0. Bytes beyond an operand's own length are ignored and read as zero digits.
- R6: The result is `len_a`+1 bytes on `out_valid`, in consecutive cycles, lowest-order first, with the same digit layout as R5.
- R7: When a magnitude subtraction would go below zero, the output is the true magnitude of the difference, and its sign is the inverse of A's sign.
- R8: A result whose magnitude within A's length is zero always carries the plus sign of the selected style.
- R9: If the exact result has a nonzero digit or carry beyond A's digit positions, `overflow` is 1, `cc` is 11, and the output holds the low-order digits truncated to A's length.
- R10: `cc` is 00 for zero, 01 for negative and 10 for positive. `done` pulses in the cycle of the last result byte, and `cc`, `overflow` and `data_err` hold their values until the next accepted command.
- R11: `ready` is high only when the unit is idle. A `start` while busy is ignored, and `ready` returns the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept a new command when ready |
| op_sub | input | 1 | 0 add, 1 subtract B from A |
| sign_mode | input | 1 | Result sign style (R3) |
| len_a | input | 4 | A byte count minus one |
| len_b | input | 4 | B byte count minus one |
| in_valid | input | 1 | Operand byte pair present |
| a_byte | input | 8 | Operand A byte |
| b_byte | input | 8 | Operand B byte |
| ready | output | 1 | Idle, command may start |
| out_valid | output | 1 | Result byte present |
| out_byte | output | 8 | Result byte |
| done | output | 1 | Completion pulse |
| cc | output | 2 | Condition code |
| overflow | output | 1 | Result exceeded A's field |
| data_err | output | 1 | Invalid digit or sign seen |

## Verification
The bench targets three kinds of subtraction:
- a subtraction whose result goes negative, where a unit that skips the recomplement would emit the raw tens-complement digits with the wrong sign;
- a subtraction of equal magnitudes, where a careless sign path would produce a negative zero;
- an operand B longer than A, where a missed carry or digit above A's field would hide an overflow.

It feeds illegal nibbles into bytes beyond an operand's length, and a design that checked or summed them would raise a spurious data error or a wrong sum. It walks all six input sign codes, both output sign styles, the full 16-byte length and stalls in the input stream. A wrong sign decode, a wrong sign pair or a lost byte therefore shows up as a byte miscompare.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    typedef logic [3:0] nib_t;

    typedef struct packed {
        nib_t d;
        logic co;
    } dig_res_t;

    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_FIX, S_OUT} state_t;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2,
        CC_OVF  = 2'd3
    } cc_t;

    function automatic logic is_digit(input nib_t n);
        return n <= 4'd9;
    endfunction

    function automatic logic sign_is_minus(input nib_t n);
        return (n == 4'hB) || (n == 4'hD);
    endfunction

    function automatic nib_t make_sign(input logic mode, input logic neg);
        nib_t s;
        case ({mode, neg})
            2'b00:   s = 4'hC;
            2'b01:   s = 4'hD;
            2'b10:   s = 4'hA;
            default: s = 4'hB;
        endcase
        return s;
    endfunction

    // One decimal digit step: add with carry or subtract with borrow.
    function automatic dig_res_t dec_digit(input nib_t x, input nib_t y,
                                           input logic ci, input logic sub);
        dig_res_t   r;
        logic [4:0] t;
        if (!sub) begin
            t = {1'b0, x} + {1'b0, y} + {4'b0, ci};
            if (t > 5'd9) begin
                r.d  = 4'(t - 5'd10);
                r.co = 1'b1;
            end else begin
                r.d  = t[3:0];
                r.co = 1'b0;
            end
        end else begin
            t = {1'b0, x} - {1'b0, y} - {4'b0, ci};
            if (t[4]) begin
                r.d  = 4'(t + 5'd10);
                r.co = 1'b1;
            end else begin
                r.d  = t[3:0];
                r.co = 1'b0;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pdec_byte_alu.sv
module pdec_byte_alu
    import pdec_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         c_i,
    input  logic         sub_i,
    output logic [W-1:0] z_o,
    output logic         c_o
);
    logic [DIGITS:0] chain;
    assign chain[0] = c_i;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        dig_res_t r;
        assign r              = dec_digit(x_i[4*g +: 4], y_i[4*g +: 4], chain[g], sub_i);
        assign z_o[4*g +: 4]  = r.d;
        assign chain[g+1]     = r.co;
    end

    assign c_o = chain[DIGITS];
endmodule

// File: rtl/pdec_sign_unit.sv
module pdec_sign_unit
    import pdec_pkg::*;
(
    input  nib_t a_sign_i,
    input  nib_t b_sign_i,
    input  logic mode_i,
    input  logic res_neg_i,
    input  logic res_zero_i,
    output logic a_neg_o,
    output logic b_neg_o,
    output logic sign_bad_o,
    output nib_t sign_o
);
    assign a_neg_o    = sign_is_minus(a_sign_i);
    assign b_neg_o    = sign_is_minus(b_sign_i);
    assign sign_bad_o = is_digit(a_sign_i) | is_digit(b_sign_i);
    // R8: a zero magnitude never gets the minus code
    assign sign_o     = make_sign(mode_i, res_neg_i & ~res_zero_i);
endmodule

// File: rtl/pdec_rbuf.sv
module pdec_rbuf #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pdec_addsub_unit.sv
module pdec_addsub_unit
    import pdec_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    localparam int LEN_W = $clog2(MAX_BYTES),
    localparam int BYTE_W = 8,
    localparam int DPB = BYTE_W / 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              op_sub,
    input  logic              sign_mode,
    input  logic [LEN_W-1:0]  len_a,
    input  logic [LEN_W-1:0]  len_b,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] a_byte,
    input  logic [BYTE_W-1:0] b_byte,
    output logic              ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              done,
    output logic [1:0]        cc,
    output logic              overflow,
    output logic              data_err
);
    state_t             state;
    logic               sub_q, mode_q;
    logic [LEN_W-1:0]   la_q, lb_q, idx;
    logic               carry_q, effsub_q, aneg_q, err_q, brw_q, nzin_q, nzout_q;
    logic               out_sign_q;
    nib_t               sign_seen_q;

    logic [LEN_W-1:0]   wmax;
    logic               first, at_last, use_a, use_b, in_field;
    logic [BYTE_W-1:0]  a_op, b_op, alu_x, alu_y, alu_z, rd, fix_byte, wdata;
    logic               alu_c, alu_ci, alu_sub, we;
    logic               a_neg, b_neg, sign_bad, eff_now, byte_err, recomp;
    logic               res_neg, res_zero, ovf_w;
    nib_t               sign_nib;
    cc_t                cc_next;

    assign ready    = (state == S_IDLE);
    assign wmax     = (la_q > lb_q) ? la_q : lb_q;
    assign first    = (idx == '0);
    assign at_last  = (idx == wmax);
    assign use_a    = (idx <= la_q);
    assign use_b    = (idx <= lb_q);
    assign in_field = (idx <= la_q);

    // R5: bytes past an operand's own length contribute zero digits
    assign a_op = use_a ? a_byte : '0;
    assign b_op = use_b ? b_byte : '0;

    pdec_sign_unit u_sign (
        .a_sign_i   (a_op[3:0]),
        .b_sign_i   (b_op[3:0]),
        .mode_i     (mode_q),
        .res_neg_i  (res_neg),
        .res_zero_i (res_zero),
        .a_neg_o    (a_neg),
        .b_neg_o    (b_neg),
        .sign_bad_o (sign_bad),
        .sign_o     (sign_nib)
    );

    assign eff_now = first ? (sub_q ^ a_neg ^ b_neg) : effsub_q;
    assign recomp  = effsub_q & carry_q;

    // R1: validation of the used nibbles of this byte pair
    always_comb begin
        if (first)
            byte_err = sign_bad | ~is_digit(a_op[7:4]) | ~is_digit(b_op[7:4]);
        else
            byte_err = ~is_digit(a_op[7:4]) | ~is_digit(a_op[3:0])
                     | ~is_digit(b_op[7:4]) | ~is_digit(b_op[3:0]);
    end

    // One byte ALU shared by the arithmetic pass and the recomplement pass
    always_comb begin
        if (state == S_FIX) begin
            alu_x   = '0;
            alu_y   = rd;
            alu_ci  = brw_q;
            alu_sub = 1'b1;
        end else begin
            alu_x   = first ? {a_op[7:4], 4'h0} : a_op;
            alu_y   = first ? {b_op[7:4], 4'h0} : b_op;
            alu_ci  = carry_q;
            alu_sub = eff_now;
        end
    end

    pdec_byte_alu #(.DIGITS(DPB)) u_alu (
        .x_i   (alu_x),
        .y_i   (alu_y),
        .c_i   (alu_ci),
        .sub_i (alu_sub),
        .z_o   (alu_z),
        .c_o   (alu_c)
    );

    assign fix_byte = recomp ? alu_z : rd;
    assign we       = ((state == S_LOAD) && in_valid) || (state == S_FIX);
    assign wdata    = (state == S_FIX) ? fix_byte : alu_z;

    pdec_rbuf #(.DEPTH(MAX_BYTES), .WIDTH(BYTE_W)) u_buf (
        .clk   (clk),
        .we    (we),
        .waddr (idx),
        .wdata (wdata),
        .raddr (idx),
        .rdata (rd)
    );

    assign res_neg  = aneg_q ^ recomp;
    assign res_zero = ~nzin_q;
    assign ovf_w    = (~effsub_q & carry_q) | nzout_q;

    always_comb begin
        if (ovf_w)                    cc_next = CC_OVF;
        else if (res_zero)            cc_next = CC_ZERO;
        else if (res_neg)             cc_next = CC_NEG;
        else                          cc_next = CC_POS;
    end

    always_ff @(posedge clk) begin
        out_valid  <= 1'b0;
        done       <= 1'b0;
        out_sign_q <= 1'b0;
        if (rst) begin
            state       <= S_IDLE;
            idx         <= '0;
            sub_q       <= 1'b0;
            mode_q      <= 1'b0;
            la_q        <= '0;
            lb_q        <= '0;
            carry_q     <= 1'b0;
            effsub_q    <= 1'b0;
            aneg_q      <= 1'b0;
            err_q       <= 1'b0;
            brw_q       <= 1'b0;
            nzin_q      <= 1'b0;
            nzout_q     <= 1'b0;
            out_byte    <= '0;
            cc          <= 2'd0;
            overflow    <= 1'b0;
            data_err    <= 1'b0;
            sign_seen_q <= 4'hC;
        end else begin
            if (out_valid && out_sign_q) sign_seen_q <= out_byte[3:0];
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state    <= S_LOAD;
                        sub_q    <= op_sub;
                        mode_q   <= sign_mode;
                        la_q     <= len_a;
                        lb_q     <= len_b;
                        idx      <= '0;
                        carry_q  <= 1'b0;
                        err_q    <= 1'b0;
                        brw_q    <= 1'b0;
                        nzin_q   <= 1'b0;
                        nzout_q  <= 1'b0;
                        cc       <= 2'd0;
                        overflow <= 1'b0;
                        data_err <= 1'b0;
                    end
                end
                S_LOAD: begin
                    if (in_valid) begin
                        carry_q <= alu_c;
                        err_q   <= err_q | byte_err;
                        if (first) begin
                            effsub_q <= eff_now;
                            aneg_q   <= a_neg;
                        end
                        if (at_last) begin
                            idx <= '0;
                            if (err_q | byte_err) begin
                                state    <= S_IDLE;
                                done     <= 1'b1;
                                data_err <= 1'b1;
                            end else begin
                                state <= S_FIX;
                            end
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                S_FIX: begin
                    brw_q <= alu_c;
                    if (in_field) nzin_q  <= nzin_q  | (fix_byte != '0);
                    else          nzout_q <= nzout_q | (fix_byte != '0);
                    if (at_last) begin
                        idx   <= '0;
                        state <= S_OUT;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_OUT: begin
                    out_valid  <= 1'b1;
                    out_sign_q <= first;
                    out_byte   <= first ? {rd[7:4], sign_nib} : rd;
                    if (idx == la_q) begin
                        done     <= 1'b1;
                        cc       <= cc_next;
                        overflow <= ovf_w;
                        state    <= S_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    nib_t last_sign;
    assign last_sign = out_sign_q ? out_byte[3:0] : sign_seen_q;

    p_err_silent_r1: assert property (@(posedge clk) disable iff (rst)
        done && data_err |-> !out_valid);

    p_sign_pair_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_sign_q |-> out_byte[3:1] == (mode_q ? 3'b101 : 3'b110));

    p_digits_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_byte[7:4] <= 4'd9) && (out_sign_q || out_byte[3:0] <= 4'd9));

    p_stream_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !done |=> out_valid);

    p_zero_plus_r8: assert property (@(posedge clk) disable iff (rst)
        done && !data_err && cc == 2'd0 |-> !last_sign[0]);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        done && overflow |-> cc == 2'd3);

    p_ready_back_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);
endmodule

// File: tb/pdec_addsub_unit_bench.sv
`timescale 1ns/1ps
module pdec_addsub_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, op_sub = 1'b0, sign_mode = 1'b0, in_valid = 1'b0;
    logic [3:0] len_a = '0, len_b = '0;
    logic [7:0] a_byte = '0, b_byte = '0;
    logic       ready, out_valid, done, overflow, data_err;
    logic [7:0] out_byte;
    logic [1:0] cc;

    always #2.5 clk = ~clk;

    pdec_addsub_unit u_pdec_addsub_unit (
        .clk(clk), .rst(rst), .start(start), .op_sub(op_sub), .sign_mode(sign_mode),
        .len_a(len_a), .len_b(len_b), .in_valid(in_valid), .a_byte(a_byte), .b_byte(b_byte),
        .ready(ready), .out_valid(out_valid), .out_byte(out_byte), .done(done),
        .cc(cc), .overflow(overflow), .data_err(data_err)
    );

    int n_vec = 0, n_bad = 0, done_cnt = 0;
    bit finished = 0;
    int da [0:32];
    int db [0:32];
    logic [7:0] exp_q [$];
    int exp_cc, exp_ovf, exp_err, out_k;
    bit prev_ov = 0, prev_done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Cycle monitor: compares every clock against the model queue
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL R6: actual extra byte %0h expected none", out_byte);
                end else begin
                    chk(out_k == 0 ? "R3 R4 sign byte" : "R4 digit byte", out_byte, exp_q.pop_front());
                end
                out_k++;
            end
            if (prev_ov && !prev_done && !out_valid) chk("R6 gap in output", 0, 1);
            if (done) begin
                chk("R10 cc", cc, exp_cc);
                chk("R9 overflow", overflow, exp_ovf);
                chk("R1 data_err", data_err, exp_err);
                chk("R6 byte count", exp_q.size(), 0);
                done_cnt++;
            end
            prev_ov = out_valid;
            prev_done = done;
        end
    end

    function automatic logic [7:0] mk_byte(int k, int l, int s, bit is_a);
        if (k > l) return 8'hFF;   // R5: garbage beyond the field
        if (k == 0) return {4'(is_a ? da[0] : db[0]), 4'(s)};
        return is_a ? {4'(da[2*k]), 4'(da[2*k-1])} : {4'(db[2*k]), 4'(db[2*k-1])};
    endfunction

    task automatic model(input bit sub, input bit mode, input int la, input int lb,
                         input int sa, input int sb);
        int ma [0:32]; int mb [0:32]; int r [0:32];
        bit err, na, nb, neg, eff, zero, ovf, a_ge;
        int c;
        err = (sa <= 9) || (sb <= 9);
        for (int i = 0; i <= 32; i++) begin
            ma[i] = (i <= 2*la) ? da[i] : 0;
            mb[i] = (i <= 2*lb) ? db[i] : 0;
            if (ma[i] > 9 || mb[i] > 9) err = 1;
        end
        exp_q.delete();
        out_k = 0;
        if (err) begin
            exp_err = 1; exp_cc = 0; exp_ovf = 0;
            return;
        end
        na = (sa == 11 || sa == 13);
        nb = (sb == 11 || sb == 13);
        eff = sub ^ na ^ nb;
        neg = na;
        if (!eff) begin
            c = 0;
            for (int i = 0; i <= 32; i++) begin
                r[i] = ma[i] + mb[i] + c;
                c = r[i] / 10; r[i] = r[i] % 10;
            end
        end else begin
            a_ge = 1;
            for (int i = 32; i >= 0; i--)
                if (ma[i] != mb[i]) begin a_ge = ma[i] > mb[i]; break; end
            c = 0;
            for (int i = 0; i <= 32; i++) begin
                r[i] = a_ge ? ma[i] - mb[i] - c : mb[i] - ma[i] - c;
                c = (r[i] < 0) ? 1 : 0;
                if (r[i] < 0) r[i] += 10;
            end
            if (!a_ge) neg = !na;
        end
        zero = 1; ovf = 0;
        for (int i = 0; i <= 32; i++) begin
            if (i <= 2*la && r[i] != 0) zero = 0;
            if (i > 2*la && r[i] != 0) ovf = 1;
        end
        if (zero) neg = 0;
        exp_err = 0;
        exp_ovf = ovf;
        exp_cc = ovf ? 3 : zero ? 0 : neg ? 1 : 2;
        for (int k = 0; k <= la; k++) begin
            if (k == 0)
                exp_q.push_back({4'(r[0]), mode ? (neg ? 4'hB : 4'hA) : (neg ? 4'hD : 4'hC)});
            else
                exp_q.push_back({4'(r[2*k]), 4'(r[2*k-1])});
        end
    endtask

    task automatic run_op(input bit sub, input bit mode, input int la, input int lb,
                          input int sa, input int sb, input bit gap, input bit stray);
        int w, d0, t;
        model(sub, mode, la, lb, sa, sb);
        w = (la > lb ? la : lb) + 1;
        @(negedge clk);
        while (!ready) @(negedge clk);
        start = 1; op_sub = sub; sign_mode = mode; len_a = 4'(la); len_b = 4'(lb);
        d0 = done_cnt;
        @(negedge clk);
        start = 0;
        chk("R11 busy after start", ready, 0);
        for (int k = 0; k < w; k++) begin
            in_valid = 1;
            a_byte = mk_byte(k, la, sa, 1);
            b_byte = mk_byte(k, lb, sb, 0);
            start = stray && (k == 0);   // R11: ignored while busy
            @(negedge clk);
            start = 0;
            if (gap && k == 0) begin
                in_valid = 0; a_byte = 8'h5A; b_byte = 8'hA5;
                @(negedge clk);
            end
        end
        in_valid = 0;
        t = 0;
        while (done_cnt == d0 && t < 200) begin @(negedge clk); t++; end
        if (done_cnt == d0) chk("R10 done timeout", 0, 1);
        @(negedge clk);
        chk("R11 ready after done", ready, 1);
    endtask

    task automatic set_num(input bit is_a, input longint v);
        for (int i = 0; i <= 32; i++) begin
            if (is_a) da[i] = int'(v % 10); else db[i] = int'(v % 10);
            v = v / 10;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            finished = 1;
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R11 reset ready", ready, 1);
        chk("R10 reset done", done, 0);
        chk("R6 reset out_valid", out_valid, 0);
        chk("R10 reset cc", cc, 0);
        chk("R1 reset data_err", data_err, 0);
        // R4: plain add
        set_num(1, 123); set_num(0, 45);
        run_op(0, 0, 1, 1, 12, 12, 0, 0);
        // R7 R9: 5 - 123 with B longer than A
        set_num(1, 5); set_num(0, 123);
        run_op(1, 0, 0, 1, 12, 12, 0, 0);
        // R7: 12 - 345, style 1
        set_num(1, 12); set_num(0, 345);
        run_op(1, 1, 1, 1, 10, 15, 0, 0);
        // R8: -25 - (-25) is plus zero
        set_num(1, 25); set_num(0, 25);
        run_op(1, 0, 1, 1, 13, 13, 0, 0);
        run_op(1, 1, 1, 1, 11, 11, 0, 0);
        // R9: 999 + 1 overflows to truncated zero
        set_num(1, 999); set_num(0, 1);
        run_op(0, 0, 1, 0, 12, 12, 0, 0);
        // R2: every sign code pair
        set_num(1, 70); set_num(0, 8);
        foreach (da[i]) ;
        for (int s1 = 10; s1 <= 15; s1++)
            for (int s2 = 10; s2 <= 15; s2++)
                run_op(s1[0], s2[0], 1, 0, s1, s2, 0, 0);
        // R1: bad digit, bad sign
        set_num(1, 12); set_num(0, 3); da[1] = 12;
        run_op(0, 0, 1, 0, 12, 12, 0, 0);
        set_num(1, 12);
        run_op(0, 0, 1, 0, 12, 7, 0, 0);
        // R5: short A, long B of garbage-free digits, garbage beyond A
        set_num(1, 4); set_num(0, 0);
        run_op(0, 1, 0, 3, 12, 12, 1, 1);
        // R5 R6: full length operands
        for (int i = 0; i <= 30; i++) begin da[i] = 9; db[i] = (i * 7) % 10; end
        for (int i = 31; i <= 32; i++) begin da[i] = 0; db[i] = 0; end
        run_op(0, 0, 15, 15, 12, 12, 0, 0);
        run_op(1, 1, 15, 15, 12, 10, 1, 0);
        // random sweep
        for (int n = 0; n < 300; n++) begin
            int la, lb;
            la = $urandom_range(0, 15); lb = $urandom_range(0, 15);
            for (int i = 0; i <= 32; i++) begin
                da[i] = (i <= 30) ? $urandom_range(0, 9) : 0;
                db[i] = (i <= 30) ? $urandom_range(0, 9) : 0;
            end
            if (n % 17 == 0) for (int i = 0; i <= 32; i++) db[i] = da[i];
            run_op($urandom_range(0, 1), $urandom_range(0, 1), la, lb,
                   $urandom_range(10, 15), $urandom_range(10, 15),
                   (n % 5) == 0, (n % 7) == 0);
        end
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule